// File: doc/BRIEF.md
# Three-Pass Inter-Planar Shuffle Address Generator

This block drives a memory port through a three-pass scramble of an RGB image kept in external memory. The image has ROWS rows, COLS columns and three colour planes, stored plane after plane, each plane row-major. The block reads one chaotic displacement value at a time from an on-chip sequence buffer. It turns each value into a destination index, then moves image elements one at a time. A move is a read of the source element followed by a write of the same value to the destination.

The passes run in a fixed order. The first moves whole rows, with the three planes stacked into 3·ROWS rows. The second moves whole columns, with the planes placed side by side into 3·COLS columns. The third moves single pixels across all 3·ROWS·COLS pixels. The passes alternate between two image regions. Pass one copies region A to region B, pass two copies B back to A, and pass three copies A to B, where the final image lands. A one-cycle start pulse launches a run, and a one-cycle done pulse marks its end.

Top module: `perm_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, done and mem_req stay low until a start pulse arrives.
- R2: The passes run in the order rows, columns, pixels. Their displacements sit in the sequence buffer at addresses 0..3·ROWS-1 (rows), 3·ROWS..3·ROWS+3·COLS-1 (columns) and 3·ROWS+3·COLS..3·ROWS+3·COLS+PIX-1 (pixels), with PIX = 3·ROWS·COLS. With all displacements zero, each pass copies in place and the final region B equals the original region A.
- R3: Row pass: rows j = 0..3·ROWS-1 are handled in ascending order, and row j uses displacement d_j. Its COLS elements, c ascending, move from base_a + j·COLS + c to base_b + ((j + d_j mod 3·ROWS) mod 3·ROWS)·COLS + c.
- R4: Column pass: columns k = 0..3·COLS-1 are handled in ascending order. Column k lies in plane k/COLS at in-plane column k mod COLS. Its element at row r sits at offset (k/COLS)·ROWS·COLS + r·COLS + (k mod COLS). For r ascending, the element moves from base_b plus the offset of k to base_a plus the offset of (k + d_k mod 3·COLS) mod 3·COLS.
- R5: Pixel pass: pixels i = 0..PIX-1 are handled in ascending order. Pixel i moves from base_a + i to base_b + ((i + d_i mod PIX) mod PIX).
- R6: Every displacement is reduced modulo its pass range, whatever its raw value, so every address issued lies inside region A or region B.
- R7: Every move is one read followed by one write carrying the value read. Only one transaction is outstanding at a time, and a run makes exactly 6·PIX transactions.
- R8: done is high for exactly one cycle, in the cycle after the acknowledge of the last pixel-pass write, once per run.
- R9: A start pulse that arrives while a run is in progress is ignored.
- R10: While mem_req is high and mem_ack is low, mem_addr, mem_we and mem_wdata hold steady. Any number of wait cycles is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse, taken only when idle |
| base_a | input | AW | Start address of region A (holds the source image) |
| base_b | input | AW | Start address of region B (receives the final image) |
| seq_addr | output | SQW | Sequence buffer read address |
| seq_data | input | DW | Displacement value, valid one cycle after seq_addr |
| mem_req | output | 1 | Memory transaction request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Element address |
| mem_wdata | output | PW | Write data |
| mem_rdata | input | PW | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | One-cycle transaction acknowledge |
| done | output | 1 | One-cycle completion pulse |

## Verification
The address-range and ordering assertions take the two regions as non-overlapping and take base_a and base_b as constant for a whole run. They also assume mem_ack comes only while mem_req is high, for one cycle per transaction. The sequence buffer is taken to answer with exactly one cycle of read latency. The bench stays inside these assumptions. Its regions are fixed at 0 and 64. Its memory model raises a single acknowledge after a programmable number of wait cycles and then drops it. Its sequence model is a registered array lookup. Raw displacements span the full 8-bit range, so the modulo reduction is exercised without leaving the stated input contract.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef enum logic [1:0] {
    PASS_ROW = 2'd0,
    PASS_COL = 2'd1,
    PASS_PIX = 2'd2
  } pass_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEQ  = 3'd1,
    ST_CALC = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4
  } walk_e;

endpackage

// File: rtl/perm_wrap_add.sv
// Destination index for one pass: (idx + disp mod RANGE) mod RANGE.
module perm_wrap_add #(
  parameter int RANGE = 9,
  parameter int DW    = 8,
  parameter int LW    = 6
) (
  input  logic [DW-1:0] disp,
  input  logic [LW-1:0] idx,
  output logic [LW-1:0] dest
);

  logic [31:0] red;
  logic [31:0] sum;

  always_comb begin
    red = 32'(disp) % 32'(RANGE);
    sum = 32'(idx) + red;
    if (sum >= 32'(RANGE)) begin
      sum = sum - 32'(RANGE);
    end
    dest = LW'(sum);
  end

endmodule

// File: rtl/perm_addr_map.sv
// Maps pass, line, element and destination line to source/destination addresses.
module perm_addr_map
  import perm_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 4,
  parameter int AW   = 16,
  parameter int LW   = 6
) (
  input  pass_e         pass,
  input  logic [LW-1:0] line_idx,
  input  logic [LW-1:0] elem_idx,
  input  logic [LW-1:0] dline_idx,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);

  localparam logic [AW-1:0] NCOL   = AW'(COLS);
  localparam logic [AW-1:0] NCOL2  = AW'(2 * COLS);
  localparam logic [AW-1:0] PLANE  = AW'(ROWS * COLS);
  localparam logic [AW-1:0] PLANE2 = AW'(2 * ROWS * COLS);

  function automatic logic [AW-1:0] col_off(input logic [LW-1:0] k,
                                            input logic [LW-1:0] r);
    logic [AW-1:0] kk;
    logic [AW-1:0] p_off;
    logic [AW-1:0] c;
    kk = AW'(k);
    if (kk >= NCOL2) begin
      p_off = PLANE2;
      c     = kk - NCOL2;
    end else if (kk >= NCOL) begin
      p_off = PLANE;
      c     = kk - NCOL;
    end else begin
      p_off = '0;
      c     = kk;
    end
    return p_off + AW'(r) * NCOL + c;
  endfunction

  always_comb begin
    case (pass)
      PASS_ROW: begin
        src_addr = base_a + AW'(line_idx) * NCOL + AW'(elem_idx);
        dst_addr = base_b + AW'(dline_idx) * NCOL + AW'(elem_idx);
      end
      PASS_COL: begin
        src_addr = base_b + col_off(line_idx, elem_idx);
        dst_addr = base_a + col_off(dline_idx, elem_idx);
      end
      default: begin
        src_addr = base_a + AW'(line_idx);
        dst_addr = base_b + AW'(dline_idx);
      end
    endcase
  end

endmodule

// File: rtl/perm_addr_gen.sv
module perm_addr_gen
  import perm_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 4,
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int PW   = 8,
  localparam int PIX     = 3 * ROWS * COLS,
  localparam int SEQ_LEN = 3 * ROWS + 3 * COLS + PIX,
  localparam int SQW     = $clog2(SEQ_LEN),
  localparam int LW      = $clog2(PIX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  base_a,
  input  logic [AW-1:0]  base_b,
  output logic [SQW-1:0] seq_addr,
  input  logic [DW-1:0]  seq_data,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [PW-1:0]  mem_wdata,
  input  logic [PW-1:0]  mem_rdata,
  input  logic           mem_ack,
  output logic           done
);

  localparam logic [LW-1:0]  ROW_LAST   = LW'(3 * ROWS - 1);
  localparam logic [LW-1:0]  COL_LAST   = LW'(3 * COLS - 1);
  localparam logic [LW-1:0]  PIX_LAST   = LW'(PIX - 1);
  localparam logic [LW-1:0]  RELEM_LAST = LW'(COLS - 1);
  localparam logic [LW-1:0]  CELEM_LAST = LW'(ROWS - 1);
  localparam logic [SQW-1:0] SQ_COL     = SQW'(3 * ROWS);
  localparam logic [SQW-1:0] SQ_PIX     = SQW'(3 * ROWS + 3 * COLS);

  walk_e         state_q, state_d;
  pass_e         pass_q, pass_d;
  logic [LW-1:0] line_q, line_d;
  logic [LW-1:0] elem_q, elem_d;
  logic [LW-1:0] dline_q;
  logic [PW-1:0] data_q;
  logic          done_q, done_d;

  logic          calc_en;
  logic          cap_en;
  logic          line_last;
  logic          elem_last;
  logic [LW-1:0] dline_sel;
  logic [LW-1:0] wrap_dest [3];
  logic [AW-1:0] src_addr;
  logic [AW-1:0] dst_addr;

  // one reducer per pass, each with a constant modulus
  for (genvar g = 0; g < 3; g++) begin : g_wrap
    localparam int RNG = (g == 0) ? 3 * ROWS : (g == 1) ? 3 * COLS : PIX;
    perm_wrap_add #(.RANGE(RNG), .DW(DW), .LW(LW)) u_wrap (
      .disp (seq_data),
      .idx  (line_q),
      .dest (wrap_dest[g])
    );
  end

  perm_addr_map #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .LW(LW)) u_map (
    .pass      (pass_q),
    .line_idx  (line_q),
    .elem_idx  (elem_q),
    .dline_idx (dline_q),
    .base_a    (base_a),
    .base_b    (base_b),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr)
  );

  always_comb begin
    case (pass_q)
      PASS_ROW: begin
        line_last = (line_q == ROW_LAST);
        elem_last = (elem_q == RELEM_LAST);
        dline_sel = wrap_dest[0];
        seq_addr  = SQW'(line_q);
      end
      PASS_COL: begin
        line_last = (line_q == COL_LAST);
        elem_last = (elem_q == CELEM_LAST);
        dline_sel = wrap_dest[1];
        seq_addr  = SQ_COL + SQW'(line_q);
      end
      default: begin
        line_last = (line_q == PIX_LAST);
        elem_last = 1'b1;
        dline_sel = wrap_dest[2];
        seq_addr  = SQ_PIX + SQW'(line_q);
      end
    endcase
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    pass_d  = pass_q;
    line_d  = line_q;
    elem_d  = elem_q;
    done_d  = 1'b0;
    calc_en = 1'b0;
    cap_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          pass_d  = PASS_ROW;
          line_d  = '0;
          elem_d  = '0;
          state_d = ST_SEQ;
        end
      end
      ST_SEQ: begin
        state_d = ST_CALC;
      end
      ST_CALC: begin
        calc_en = 1'b1;
        state_d = ST_RD;
      end
      ST_RD: begin
        if (mem_ack) begin
          cap_en  = 1'b1;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (mem_ack) begin
          if (!elem_last) begin
            elem_d  = elem_q + LW'(1);
            state_d = ST_RD;
          end else begin
            elem_d = '0;
            if (!line_last) begin
              line_d  = line_q + LW'(1);
              state_d = ST_SEQ;
            end else begin
              line_d = '0;
              if (pass_q == PASS_PIX) begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
              end else begin
                pass_d  = pass_e'(pass_q + 2'd1);
                state_d = ST_SEQ;
              end
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= PASS_ROW;
      line_q  <= '0;
      elem_q  <= '0;
      dline_q <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      line_q  <= line_d;
      elem_q  <= elem_d;
      done_q  <= done_d;
      if (calc_en) begin
        dline_q <= dline_sel;
      end
      if (cap_en) begin
        data_q <= mem_rdata;
      end
    end
  end

  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = (state_q == ST_WR) ? dst_addr : src_addr;
  assign mem_wdata = data_q;
  assign done      = done_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we)); // R7
  AST_WR_CARRIES_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_wdata == $past(mem_rdata))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_we && mem_ack)); // R8
  AST_ADDR_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr >= base_a && mem_addr < base_a + AW'(PIX)) ||
                 (mem_addr >= base_b && mem_addr < base_b + AW'(PIX)))); // R6
  AST_PASS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass_q) |-> ((pass_q == PASS_COL && $past(pass_q) == PASS_ROW) ||
                          (pass_q == PASS_PIX && $past(pass_q) == PASS_COL) ||
                          (pass_q == PASS_ROW && $past(state_q) == ST_IDLE))); // R2

endmodule

// File: tb/sim_perm_addr_gen.sv
module sim_perm_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int M   = 3;
  localparam int N   = 4;
  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int PW  = 8;
  localparam int PIX = 3 * M * N;
  localparam int SQW = $clog2(3 * M + 3 * N + PIX);
  localparam int RA  = 0;
  localparam int RB  = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [SQW-1:0] seq_addr;
  logic [DW-1:0]  seq_data;
  logic           mem_req;
  logic           mem_we;
  logic [AW-1:0]  mem_addr;
  logic [PW-1:0]  mem_wdata;
  logic [PW-1:0]  mem_rdata;
  logic           mem_ack;
  logic           done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  perm_addr_gen #(.ROWS(M), .COLS(N), .AW(AW), .DW(DW), .PW(PW)) u0 (
    .clk, .rst_n, .start,
    .base_a (AW'(RA)),
    .base_b (AW'(RB)),
    .seq_addr, .seq_data,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
    .done
  );

  // models
  logic [7:0] mem      [0:127];
  logic [7:0] img_init [0:127];
  logic [7:0] exp_mem  [0:127];
  logic [7:0] seq_mem  [0:63];
  logic       load = 1'b0;
  int         lat = 0;
  int         wait_cnt, txn, oor, done_cnt, done_bad;
  int         first_wr;
  logic       wr_ack_prev, done_prev;

  always @(posedge clk) seq_data <= seq_mem[seq_addr];

  always @(posedge clk) begin
    wr_ack_prev <= mem_ack && mem_req && mem_we;
    done_prev   <= done;
    if (load) begin
      for (int i = 0; i < 128; i++) mem[i] <= img_init[i];
      txn <= 0; oor <= 0; done_cnt <= 0; done_bad <= 0;
      mem_ack <= 1'b0; wait_cnt <= 0; first_wr <= -1;
    end else begin
      if (done) begin
        done_cnt <= done_cnt + 1;
        if (!wr_ack_prev || done_prev) done_bad <= done_bad + 1;
      end
      if (mem_ack) begin
        mem_ack <= 1'b0;
      end else if (mem_req) begin
        if (wait_cnt < lat) begin
          wait_cnt <= wait_cnt + 1;
        end else begin
          wait_cnt <= 0;
          mem_ack  <= 1'b1;
          txn      <= txn + 1;
          if (mem_addr >= 16'd128) oor <= oor + 1;
          else if (mem_we) begin
            mem[mem_addr[6:0]] <= mem_wdata;
            if (first_wr < 0) first_wr <= int'(mem_addr);
          end else mem_rdata <= mem[mem_addr[6:0]];
        end
      end
    end
  end

  int nchk = 0;
  int nfail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp_v,
                       input string what);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  function automatic int col_off(input int k, input int r);
    return (k / N) * M * N + r * N + (k % N);
  endfunction

  task automatic build_expect();
    for (int i = 0; i < 128; i++) exp_mem[i] = img_init[i];
    for (int j = 0; j < 3 * M; j++) begin
      int dj = (j + int'(seq_mem[j]) % (3 * M)) % (3 * M);
      for (int c = 0; c < N; c++) exp_mem[RB + dj * N + c] = exp_mem[RA + j * N + c];
    end
    for (int k = 0; k < 3 * N; k++) begin
      int dk = (k + int'(seq_mem[3 * M + k]) % (3 * N)) % (3 * N);
      for (int r = 0; r < M; r++) exp_mem[RA + col_off(dk, r)] = exp_mem[RB + col_off(k, r)];
    end
    for (int i = 0; i < PIX; i++) begin
      int di = (i + int'(seq_mem[3 * M + 3 * N + i]) % PIX) % PIX;
      exp_mem[RB + di] = exp_mem[RA + i];
    end
  endtask

  task automatic fill_seq(input int mul, input int add);
    for (int i = 0; i < 64; i++) seq_mem[i] = 8'((i * mul + add) % 256);
  endtask

  task automatic run_case(input string req, input int lat_v, input bit poke);
    int cyc = 0;
    lat = lat_v;
    build_expect();
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (done_cnt == 0 && cyc < 50000) begin
      @(negedge clk);
      cyc++;
    end
    check(done_cnt > 0, req, cyc, 0, "run did not finish");
    repeat (10) @(negedge clk);
    check(done_cnt == 1, "R8", done_cnt, 1, {req, " done pulse count"});
    check(done_bad == 0, "R8", done_bad, 0, {req, " done timing/width"});
    check(txn == 6 * PIX, "R7", txn, 6 * PIX, {req, " transaction count"});
    check(oor == 0, "R6", oor, 0, {req, " out-of-range accesses"});
    check(mem_req == 1'b0, "R9", int'(mem_req), 0, {req, " idle after run"});
    check(first_wr == RB + ((int'(seq_mem[0]) % (3 * M)) % (3 * M)) * N, "R3", first_wr,
          RB + ((int'(seq_mem[0]) % (3 * M)) % (3 * M)) * N, {req, " first row write"});
    for (int i = 0; i < PIX; i++)
      check(mem[RA + i] == exp_mem[RA + i], "R4", int'(mem[RA + i]), int'(exp_mem[RA + i]),
            {req, " region A after column pass"});
    for (int i = 0; i < PIX; i++)
      check(mem[RB + i] == exp_mem[RB + i], "R5", int'(mem[RB + i]), int'(exp_mem[RB + i]),
            {req, " region B after pixel pass"});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", int'(done), 0, "done in reset");
    check(mem_req == 1'b0, "R1", int'(mem_req), 0, "mem_req in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(done == 1'b0, "R1", int'(done), 0, "done after reset");
    check(mem_req == 1'b0, "R1", int'(mem_req), 0, "mem_req after reset");
  endtask

  task automatic t_identity();
    fill_seq(0, 0);
    run_case("R2", 0, 1'b0);
    for (int i = 0; i < PIX; i++)
      check(mem[RB + i] == img_init[RA + i], "R2", int'(mem[RB + i]), int'(img_init[RA + i]),
            "zero displacements give identity");
  endtask

  task automatic t_pattern();
    fill_seq(7, 3);
    run_case("R3", 0, 1'b0);
  endtask

  task automatic t_large_disp();
    fill_seq(1, 200);
    run_case("R6", 0, 1'b0);
  endtask

  task automatic t_slow_mem();
    fill_seq(13, 5);
    run_case("R10", 3, 1'b0);
  endtask

  task automatic t_start_busy();
    fill_seq(29, 17);
    run_case("R9", 1, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not end, actual 1 expected 0");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 128; i++) img_init[i] = 8'((i * 37 + 11) % 256);
    fill_seq(0, 0);
    t_reset();
    t_identity();
    t_pattern();
    t_large_disp();
    t_slow_mem();
    t_start_busy();
    finish_up();
  end

endmodule